// File: doc/BRIEF.md
# Oversampling Serial Receiver with Bit Re-centring

This block is the receive front end of an asynchronous serial port. It takes a raw serial line and recovers 8-bit frames made of one low start bit, eight data bits sent least significant bit first, and one high stop bit. For each frame it produces a data byte, a one-cycle valid strobe, a framing error flag, and a flag that reports when the line has stayed idle. The serial line and a baud-rate clock both arrive asynchronously. Each one passes through a two-flop synchronizer before the block detects any edge on it.

The baud-rate clock is counted in units of "ticks". A tick is a rising edge of the baud-rate clock. When dual-edge sampling is active, a falling edge is also a tick. A 5-bit ratio field sets how many baud-rate clock periods make one bit. Dual-edge sampling gives twice as many ticks per bit for the same ratio, and it is always on for the smallest ratios. Each data bit is settled by a majority vote of three ticks around the bit centre. By default the receiver re-centres its bit timing on every high-to-low transition inside a word, so it tolerates a sender whose rate is off.

Software sets the ratio, the dual-edge enable and the re-centring disable. The block takes a new value into use only while the receiver is disabled.

Top module: `osr_uart_rx`

## Requirements
- R1: The ratio field value v selects a ratio of v+1 baud-rate clock periods per bit, so 11111b gives 32. Field values below 3 are raised to a ratio of 4.
- R2: When the ratio is below 8, ticks occur on both edges of the baud-rate clock whatever `dual_edge_en` says. When the ratio is 8 or more, falling-edge ticks occur only if `dual_edge_en` is 1. In both cases a bit lasts the same time.
- R3: A frame begins on a high-to-low edge of the synchronized line. If the line is high again at the middle tick of the start bit, the block treats it as a false start, returns to waiting and delivers nothing.
- R4: Each data bit is the 2-of-3 majority of the line at ticks half-1, half and half+1 of the bit, where half is the number of ticks per bit divided by two. The eight bits fill `rx_data` least significant bit first.
- R5: If the stop bit votes low, `frame_err` is 1 and the byte is still delivered with `rx_valid`. If the stop bit votes high, `frame_err` is 0.
- R6: `rx_valid` is high for exactly one clock per received frame. `rx_data` and `frame_err` keep their values until the next frame is delivered.
- R7: While `resync_dis` is 0, a high-to-low edge inside the data bits restarts the bit counter. Such an edge after the current bit's vote starts the next bit. An edge before the vote restarts the current bit. This keeps frames whose bits are 15% longer than nominal intact.
- R8: While `resync_dis` is 1, bit timing runs from the start edge alone. A frame whose bits are 15% longer than nominal then samples its stop bit during data bit 7 and reports `frame_err` = 1.
- R9: The block uses the current `osr_field`, `dual_edge_en` and `resync_dis` only while `rx_en` is 0. A change made while `rx_en` is 1 takes effect after the next time `rx_en` is 0.
- R10: `idle_line` rises once the line has stayed high for ten bit times after a stop bit has been sampled. It falls on the next start edge.
- R11: After reset, `rx_data` is 0 and `rx_valid`, `frame_err` and `idle_line` are 0. While `rx_en` is 0, `idle_line` is 0 and no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; configuration is taken in while low |
| baud_clk | input | 1 | Baud-rate clock, asynchronous, much slower than clk |
| osr_field | input | 5 | Ratio field; ratio = value + 1, minimum 4 |
| dual_edge_en | input | 1 | Tick on both baud clock edges (forced for ratio below 8) |
| resync_dis | input | 1 | 1 disables re-centring on in-word falling edges |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when a frame is delivered |
| frame_err | output | 1 | Stop bit of the last frame was low |
| idle_line | output | 1 | Line has been idle for a full frame time |

## Verification
The assertions watch several properties on every cycle. `rx_valid` never lasts two cycles and only follows a stop-bit vote. The frame engine enters its start state only after a line fall. The tick counter never passes the last tick of a bit. With re-centring off, the counter moves only on ticks. The configuration stays frozen while enabled. The idle flag rises only from an armed count and drops after a start edge. The assertions cannot show end results, and only the bench scenarios do. These are the correct byte under each ratio and edge mode, the forced dual-edge mode at ratio 4, false-start rejection, the framing error, the timing of the idle flag, and the hold on configuration. They also include the contrast between a drifting sender with re-centring on, which gives a clean byte, and with re-centring off, which gives a framing error.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  // ratio from the field value, raised to a floor
  function automatic int unsigned ratio_of(input int unsigned fld,
                                           input int unsigned floor_r);
    return ((fld + 1) < floor_r) ? floor_r : (fld + 1);
  endfunction

  // dual-edge ticking is forced below a threshold ratio
  function automatic logic dual_of(input int unsigned ratio, input logic en,
                                   input int unsigned below);
    return (ratio < below) || en;
  endfunction

  // ticks per bit
  function automatic int unsigned spb_of(input int unsigned ratio, input logic dual);
    return dual ? (2 * ratio) : ratio;
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/osr_rx_cfg.sv
module osr_rx_cfg
  import osr_rx_pkg::*;
#(
  parameter int OSR_W      = 5,
  parameter int SPB_W      = 7,
  parameter int MIN_RATIO  = 4,
  parameter int DUAL_BELOW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [OSR_W-1:0] osr_field,
  input  logic             dual_edge_en,
  input  logic             resync_dis,
  output logic [SPB_W-1:0] spb,
  output logic             dual_act,
  output logic             resync_en
);

  logic [OSR_W-1:0] field_q;
  logic             dual_q;
  logic             rsdis_q;

  // shadow copy follows the inputs only while the receiver is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= OSR_W'(15);
      dual_q  <= 1'b0;
      rsdis_q <= 1'b0;
    end else if (!rx_en) begin
      field_q <= osr_field;
      dual_q  <= dual_edge_en;
      rsdis_q <= resync_dis;
    end
  end

  int unsigned ratio;
  always_comb begin
    ratio    = ratio_of(int'(field_q), MIN_RATIO);
    dual_act = dual_of(ratio, dual_q, DUAL_BELOW);
    spb      = SPB_W'(spb_of(ratio, dual_act));
  end

  assign resync_en = !rsdis_q;

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && $past(rx_en)) |-> ($stable(spb) && $stable(dual_act) && $stable(resync_en)));

endmodule

// File: rtl/osr_rx_front.sv
module osr_rx_front (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic baud_clk,
  input  logic dual_act,
  output logic rx_s,
  output logic rx_fall,
  output logic tick
);

  logic rx_meta, rx_prev;
  logic bc_meta, bc_s, bc_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
      rx_prev <= 1'b1;
      bc_meta <= 1'b0;
      bc_s    <= 1'b0;
      bc_prev <= 1'b0;
    end else begin
      rx_meta <= rxd;
      rx_s    <= rx_meta;
      rx_prev <= rx_s;
      bc_meta <= baud_clk;
      bc_s    <= bc_meta;
      bc_prev <= bc_s;
    end
  end

  assign rx_fall = rx_prev & ~rx_s;
  assign tick    = (bc_s & ~bc_prev) | (dual_act & ~bc_s & bc_prev);

endmodule

// File: rtl/osr_rx_frame.sv
module osr_rx_frame
  import osr_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int CNT_W     = 6,
  parameter int SPB_W     = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 tick,
  input  logic                 rx_s,
  input  logic                 rx_fall,
  input  logic [SPB_W-1:0]     spb,
  input  logic                 resync_en,
  output logic [DATA_BITS-1:0] data,
  output logic                 valid,
  output logic                 ferr,
  output logic                 start_evt,
  output logic                 stop_evt
);

  localparam int BIT_W = $clog2(DATA_BITS);

  rx_state_e            st;
  logic [CNT_W-1:0]     cnt;
  logic [BIT_W-1:0]     bitn;
  logic                 s0, s1;
  logic [DATA_BITS-1:0] shreg;

  logic [CNT_W-1:0] half, half_lo, half_hi, last;
  logic maj, last_bit, rs_fall, early, late, at_vote;

  always_comb begin
    half     = CNT_W'(spb >> 1);
    half_lo  = half - CNT_W'(1);
    half_hi  = half + CNT_W'(1);
    last     = CNT_W'(spb - SPB_W'(1));
    maj      = maj3(s0, s1, rx_s);
    last_bit = (bitn == BIT_W'(DATA_BITS - 1));
    rs_fall  = resync_en && rx_fall && (st == ST_DATA);
    early    = rs_fall && (cnt < half_lo);
    late     = rs_fall && (cnt > half_hi);
    at_vote  = tick && (cnt == half_hi);
  end

  assign start_evt = rx_en && (st == ST_IDLE) && rx_fall;
  assign stop_evt  = rx_en && (st == ST_STOP) && at_vote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      s0    <= 1'b1;
      s1    <= 1'b1;
      shreg <= '0;
      data  <= '0;
      valid <= 1'b0;
      ferr  <= 1'b0;
    end else if (!rx_en) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (rx_fall) begin
            st  <= ST_START;
            cnt <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (cnt == half && rx_s) begin
              st <= ST_IDLE;
            end else if (cnt == last) begin
              st   <= ST_DATA;
              cnt  <= '0;
              bitn <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (early) begin
            cnt <= '0;
          end else if (late) begin
            cnt <= '0;
            if (last_bit) st <= ST_STOP;
            else          bitn <= bitn + BIT_W'(1);
          end else if (tick) begin
            if (cnt == half_lo) s0 <= rx_s;
            if (cnt == half)    s1 <= rx_s;
            if (cnt == half_hi) shreg <= {maj, shreg[DATA_BITS-1:1]};
            if (cnt == last) begin
              cnt <= '0;
              if (last_bit) st <= ST_STOP;
              else          bitn <= bitn + BIT_W'(1);
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (cnt == half_lo) s0 <= rx_s;
            if (cnt == half)    s1 <= rx_s;
            if (cnt == half_hi) begin
              data  <= shreg;
              ferr  <= !maj;
              valid <= 1'b1;
              st    <= ST_IDLE;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R5
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($past(st == ST_STOP) && $past(rx_en)));

  // R3
  start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_START) && $past(st == ST_IDLE)) |-> $past(rx_fall));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> (cnt <= last));

  // R8
  no_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!resync_en && (st == ST_DATA) && $past(st == ST_DATA) && (cnt != $past(cnt)))
      |-> $past(tick));

endmodule

// File: rtl/osr_rx_idle.sv
module osr_rx_idle #(
  parameter int SPB_W      = 7,
  parameter int FRAME_BITS = 10,
  parameter int IDLE_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             tick,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [SPB_W-1:0] spb,
  output logic             idle_line
);

  logic              armed;
  logic [IDLE_W-1:0] cnt;
  logic [IDLE_W-1:0] limit_m1;

  always_comb limit_m1 = IDLE_W'(FRAME_BITS * int'(spb) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      cnt       <= '0;
      idle_line <= 1'b0;
    end else if (!rx_en || start_evt) begin
      armed     <= 1'b0;
      cnt       <= '0;
      idle_line <= 1'b0;
    end else if (stop_evt) begin
      armed     <= 1'b1;
      cnt       <= '0;
      idle_line <= 1'b0;
    end else if (armed && tick) begin
      if (cnt == limit_m1) begin
        idle_line <= 1'b1;
        armed     <= 1'b0;
      end else begin
        cnt <= cnt + IDLE_W'(1);
      end
    end
  end

  // R10
  idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_line) |-> ($past(armed) && $past(tick)));

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !idle_line);

endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx #(
  parameter int OSR_W      = 5,
  parameter int DATA_BITS  = 8,
  parameter int MIN_RATIO  = 4,
  parameter int DUAL_BELOW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 baud_clk,
  input  logic [OSR_W-1:0]     osr_field,
  input  logic                 dual_edge_en,
  input  logic                 resync_dis,
  input  logic                 rxd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 frame_err,
  output logic                 idle_line
);

  localparam int MAX_RATIO  = 1 << OSR_W;
  localparam int CNT_W      = $clog2(2 * MAX_RATIO);
  localparam int SPB_W      = CNT_W + 1;
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int IDLE_W     = $clog2(FRAME_BITS * 2 * MAX_RATIO);

  logic [SPB_W-1:0] spb;
  logic dual_act, resync_en;
  logic rx_s, rx_fall, tick;
  logic start_evt, stop_evt;

  osr_rx_cfg #(
    .OSR_W(OSR_W), .SPB_W(SPB_W), .MIN_RATIO(MIN_RATIO), .DUAL_BELOW(DUAL_BELOW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .osr_field(osr_field),
    .dual_edge_en(dual_edge_en), .resync_dis(resync_dis),
    .spb(spb), .dual_act(dual_act), .resync_en(resync_en)
  );

  osr_rx_front u_front (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_clk(baud_clk), .dual_act(dual_act),
    .rx_s(rx_s), .rx_fall(rx_fall), .tick(tick)
  );

  osr_rx_frame #(
    .DATA_BITS(DATA_BITS), .CNT_W(CNT_W), .SPB_W(SPB_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(tick), .rx_s(rx_s),
    .rx_fall(rx_fall), .spb(spb), .resync_en(resync_en),
    .data(rx_data), .valid(rx_valid), .ferr(frame_err),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  osr_rx_idle #(
    .SPB_W(SPB_W), .FRAME_BITS(FRAME_BITS), .IDLE_W(IDLE_W)
  ) u_idle (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(tick),
    .start_evt(start_evt), .stop_evt(stop_evt), .spb(spb), .idle_line(idle_line)
  );

  // R11
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !$past(rx_en)) |-> (!idle_line && !rx_valid));

endmodule

// File: tb/osr_uart_rx_tb.sv
module osr_uart_rx_tb;

  localparam int BAUD_HALF = 4;              // clk cycles per baud clock half period
  localparam int BAUD_PER  = 2 * BAUD_HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       baud_clk = 1'b0;
  logic [4:0] osr_field = 5'd15;
  logic       dual_edge_en = 1'b0;
  logic       resync_dis = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       frame_err;
  logic       idle_line;

  int errors = 0;
  int checks = 0;
  int nvalid = 0;
  logic [7:0] last_data = 8'h00;
  logic       last_ferr = 1'b0;

  osr_uart_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .baud_clk(baud_clk),
    .osr_field(osr_field), .dual_edge_en(dual_edge_en), .resync_dis(resync_dis),
    .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .frame_err(frame_err), .idle_line(idle_line)
  );

  always #4 clk = ~clk;   // 125 MHz

  initial begin
    forever begin
      repeat (BAUD_HALF) @(negedge clk);
      baud_clk = ~baud_clk;
    end
  end

  // capture every delivered frame
  always @(negedge clk) begin
    if (rx_valid) begin
      nvalid    = nvalid + 1;
      last_data = rx_data;
      last_ferr = frame_err;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bit_clks(input int fld);
    int r;
    r = fld + 1;
    if (r < 4) r = 4;
    return r * BAUD_PER;
  endfunction

  task automatic configure(input int fld, input logic dual, input logic rsd);
    @(negedge clk);
    rx_en = 1'b0;
    osr_field = fld[4:0];
    dual_edge_en = dual;
    resync_dis = rsd;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_bit, input int tb);
    rxd = 1'b0;
    repeat (tb) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (tb) @(negedge clk);
    end
    rxd = stop_bit;
    repeat (tb) @(negedge clk);
    rxd = 1'b1;
    if (!stop_bit) repeat (tb) @(negedge clk);
  endtask

  task automatic frame_and_check(input string tag, input logic [7:0] b, input int tb);
    int n0;
    n0 = nvalid;
    send_frame(b, 1'b1, tb);
    check(nvalid == n0 + 1, {tag, " frame count"}, nvalid - n0, 1);
    check(last_data == b, {tag, " data"}, int'(last_data), int'(b));
    check(last_ferr == 1'b0, {tag, " frame_err"}, int'(last_ferr), 0);
    repeat (tb) @(negedge clk);
  endtask

  task automatic t_reset;
    check(rx_data == 8'h00, "R11 reset rx_data", int'(rx_data), 0);
    check(!rx_valid && !frame_err && !idle_line, "R11 reset flags",
          int'({rx_valid, frame_err, idle_line}), 0);
  endtask

  task automatic t_basic;
    configure(15, 1'b0, 1'b0);
    frame_and_check("R4 ratio16 single 0xA5", 8'hA5, bit_clks(15));
    frame_and_check("R4 ratio16 single 0x01", 8'h01, bit_clks(15));
    // R6: data held after the strobe
    check(rx_data == 8'h01 && !rx_valid, "R6 data held", int'(rx_data), 1);
  endtask

  task automatic t_ratios;
    configure(31, 1'b0, 1'b0);
    frame_and_check("R1 ratio32 0x6E", 8'h6E, bit_clks(31));
    configure(15, 1'b1, 1'b0);
    frame_and_check("R2 ratio16 dual 0xB4", 8'hB4, bit_clks(15));
    configure(7, 1'b1, 1'b0);
    frame_and_check("R2 ratio8 dual 0x3C", 8'h3C, bit_clks(7));
    configure(3, 1'b0, 1'b0);
    frame_and_check("R2 ratio4 forced dual 0x5A", 8'h5A, bit_clks(3));
    configure(1, 1'b0, 1'b0);
    frame_and_check("R1 floor ratio4 0xC9", 8'hC9, bit_clks(1));
  endtask

  task automatic t_frame_err;
    int n0;
    configure(15, 1'b0, 1'b0);
    n0 = nvalid;
    send_frame(8'h81, 1'b0, bit_clks(15));
    check(nvalid == n0 + 1, "R5 low stop still delivered", nvalid - n0, 1);
    check(last_data == 8'h81, "R5 data with framing error", int'(last_data), 'h81);
    check(last_ferr == 1'b1, "R5 frame_err set", int'(last_ferr), 1);
    frame_and_check("R5 frame_err cleared by good frame", 8'h7E, bit_clks(15));
  endtask

  task automatic t_false_start;
    int n0;
    configure(15, 1'b0, 1'b0);
    n0 = nvalid;
    rxd = 1'b0;
    repeat (2 * BAUD_PER) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * bit_clks(15)) @(negedge clk);
    check(nvalid == n0, "R3 false start rejected", nvalid - n0, 0);
    frame_and_check("R3 frame after false start", 8'h99, bit_clks(15));
  endtask

  task automatic t_idle;
    int tb;
    tb = bit_clks(15);
    configure(15, 1'b0, 1'b0);
    send_frame(8'h42, 1'b1, tb);
    repeat (8 * tb) @(negedge clk);
    check(idle_line == 1'b0, "R10 idle not yet", int'(idle_line), 0);
    repeat (5 * tb / 2) @(negedge clk);
    check(idle_line == 1'b1, "R10 idle after frame time", int'(idle_line), 1);
    fork
      send_frame(8'h0F, 1'b1, tb);
      begin
        repeat (8) @(negedge clk);
        check(idle_line == 1'b0, "R10 idle cleared by start", int'(idle_line), 0);
      end
    join
    check(last_data == 8'h0F, "R10 frame after idle", int'(last_data), 'h0F);
    repeat (11 * tb) @(negedge clk);
    check(idle_line == 1'b1, "R10 idle again", int'(idle_line), 1);
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    check(idle_line == 1'b0, "R11 idle cleared by disable", int'(idle_line), 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_disabled;
    int n0;
    configure(15, 1'b0, 1'b0);
    rx_en = 1'b0;
    n0 = nvalid;
    send_frame(8'h33, 1'b1, bit_clks(15));
    check(nvalid == n0, "R11 no frame while disabled", nvalid - n0, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_cfg_lock;
    configure(15, 1'b0, 1'b0);
    @(negedge clk);
    osr_field = 5'd7;
    dual_edge_en = 1'b1;
    repeat (4) @(negedge clk);
    frame_and_check("R9 change held while enabled", 8'hC3, bit_clks(15));
    rx_en = 1'b0;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    frame_and_check("R9 change applied after disable", 8'h96, bit_clks(7));
  endtask

  task automatic t_resync;
    int slow;
    int n0;
    slow = (bit_clks(15) * 115) / 100;
    configure(15, 1'b0, 1'b0);
    frame_and_check("R7 resync slow sender 0x55", 8'h55, slow);
    configure(15, 1'b0, 1'b1);
    n0 = nvalid;
    send_frame(8'h55, 1'b1, slow);
    repeat (bit_clks(15)) @(negedge clk);
    check(nvalid == n0 + 1, "R8 free-run frame count", nvalid - n0, 1);
    check(last_ferr == 1'b1, "R8 free-run drift frame_err", int'(last_ferr), 1);
    check(last_data[7] == 1'b1, "R8 free-run bit7 from bit6", int'(last_data[7]), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_ratios();
    t_frame_err();
    t_false_start();
    t_idle();
    t_disabled();
    t_cfg_lock();
    t_resync();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule